// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Read Slave

This block is the target side of a two-wire serial memory that holds 128 bytes. It oversamples the clock and data lines with the system clock, recognises start, repeated start and stop conditions, and matches the incoming device byte against a fixed type code and three select pins. Reads come in three forms. A random read uses a write frame to load the word address, followed by a repeated start and a read frame. A current read sends the read frame alone and returns the byte at the internal pointer. Either form turns into a sequential read for as long as the master acknowledges each byte. The data line is open-drain: the block only ever pulls it low or releases it.

The internal pointer survives from one transaction to the next. Each byte that is shifted out advances it, so a current read continues right after the last byte sent. A write frame only loads the pointer from the word address byte. Any data bytes that follow it are not accepted. When `ADDR_W` is raised above 8, the low select bits in the device byte become high address bits and are no longer compared with the pins. At the default width none of them are used this way.

The memory array is filled through a valid/ready preload stream. `pl_ready` is high only while the serial engine is idle. A byte is written on any cycle where `pl_valid` and `pl_ready` are both high. While a transaction is in progress the stream is held back, and a source has to keep `pl_valid`, `pl_addr` and `pl_data` steady until it sees `pl_ready`.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one, arriving at any point including mid-byte, abandons the frame in progress and leaves the pointer unchanged. After a stop the line is released.
- R2: The device byte is sent MSB first: bits 7:4 must be 1010, bits 3:1 must equal `dev_sel[2:0]` (bit 1 compared with `dev_sel[0]`), and bit 0 is R/W (1 = read). On a match the block pulls SDA low during the ninth clock. On a mismatch it keeps SDA released for the ACK and for every clock until the next start.
- R3: In a write frame the word address byte is acknowledged and its low 7 bits are loaded into the pointer, with bit 7 ignored. Any further data bytes in that frame get no ACK and leave the memory unchanged.
- R4: A random read returns the byte stored at the word address that was just loaded.
- R5: A current read returns the byte at the pointer. Every byte sent advances the pointer by one, so a current read after a read that ended at address n returns the byte at n+1.
- R6: When the master drives the ACK after D0 low, the next byte follows at once. The address wraps from 127 to 0.
- R7: When the master leaves the ACK after D0 high, SDA stays released until the next start and no further data is sent.
- R8: Data is sent D7 first. The SDA drive changes only after a detected SCL falling edge, or on a start or stop, and never while SCL stays high.
- R9: `pl_ready` is high only while no frame is in progress. A byte is written only on the `pl_valid && pl_ready` handshake, and `pl_valid` while `pl_ready` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_low | output | 1 | 1 = pull SDA low, 0 = release |
| dev_sel | input | 3 | Device select pins |
| pl_valid | input | 1 | Preload byte valid |
| pl_ready | output | 1 | Preload accepted this cycle when high |
| pl_addr | input | ADDR_W | Preload byte address |
| pl_data | input | 8 | Preload byte value |

## Verification
The bus inputs pass through two synchroniser flops and one edge flop, so the SDA drive moves on the third system clock after SCL falls. The bench holds every SCL half-period for 20 system clocks and samples SDA 10 clocks into the high phase, well clear of that delay. An ACK or data bit is therefore read during the SCL-high phase that follows the falling edge on which the block changed its drive. A preload write lands on the clock edge after the handshake, and its effect is checked later through a serial read of that address.

// File: rtl/i2c_eeprom_rd_pkg.sv
package i2c_eeprom_rd_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int SEL_BITS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WA_ACK,
    ST_TX,
    ST_MACK
  } eep_state_e;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_s1, sda_s1, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s1 <= 1'b1;
      sda_s1 <= 1'b1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_s1 <= scl_i;
      sda_s1 <= sda_i;
      scl_q  <= scl_s1;
      sda_q  <= sda_s1;
      scl_p  <= scl_q;
      sda_p  <= sda_q;
    end
  end

  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start_c  = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_c   = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/eep_dev_match.sv
module eep_dev_match
  import i2c_eeprom_rd_pkg::*;
#(
  parameter int PAGE_BITS = 0
) (
  input  logic [7:1]          dev_field,
  input  logic [SEL_BITS-1:0] dev_sel,
  output logic                hit,
  output logic [SEL_BITS-1:0] page
);
  logic [SEL_BITS-1:0] sel_ok;

  for (genvar g = 0; g < SEL_BITS; g++) begin : g_sel
    if (g < PAGE_BITS) begin : g_page
      assign sel_ok[g] = 1'b1;
      assign page[g]   = dev_field[g+1];
    end else begin : g_pin
      assign sel_ok[g] = (dev_field[g+1] == dev_sel[g]);
      assign page[g]   = 1'b0;
    end
  end

  assign hit = (dev_field[7:4] == DEV_TYPE) && (&sel_ok);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_rd_engine.sv
module eep_rd_engine
  import i2c_eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_c,
  input  logic                stop_c,
  input  logic                sda_in,
  input  logic                dev_hit,
  input  logic [SEL_BITS-1:0] dev_page,
  input  logic [7:0]          rd_data,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [7:1]          dev_field,
  output logic                sda_low,
  output logic                idle
);
  localparam int WIDE_W = SEL_BITS + 8;

  eep_state_e          st;
  logic [3:0]          bitcnt;
  logic [7:0]          rx_sh;
  logic [7:0]          tx_sh;
  logic [ADDR_W-1:0]   ptr;
  logic                rw_q;
  logic                mack_q;
  logic [SEL_BITS-1:0] page_q;
  logic [WIDE_W-1:0]   wa_wide;

  assign wa_wide   = {page_q, rx_sh};
  assign rd_addr   = ptr;
  assign dev_field = rx_sh[7:1];
  assign idle      = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      page_q  <= '0;
      sda_low <= 1'b0;
    end else if (start_c) begin
      st      <= ST_DEV;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (stop_c) begin
      st      <= ST_IDLE;
      sda_low <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_WADDR: begin
          if (scl_rise && bitcnt != 4'd8) begin
            rx_sh  <= {rx_sh[6:0], sda_in};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (st == ST_DEV) begin
              if (dev_hit) begin
                sda_low <= 1'b1;
                rw_q    <= rx_sh[0];
                page_q  <= dev_page;
                st      <= ST_DEV_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              ptr     <= ADDR_W'(wa_wide);
              sda_low <= 1'b1;
              st      <= ST_WA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_sh   <= rd_data;
              ptr     <= ptr + 1'b1;
              sda_low <= ~rd_data[7];
              bitcnt  <= 4'd1;
              st      <= ST_TX;
            end else begin
              sda_low <= 1'b0;
              st      <= ST_WADDR;
            end
          end
        end
        ST_WA_ACK: begin
          if (scl_fall) begin
            sda_low <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_low <= 1'b0;
              st      <= ST_MACK;
            end else begin
              tx_sh   <= tx_sh << 1;
              sda_low <= ~tx_sh[6];
              bitcnt  <= bitcnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_in;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_sh   <= rd_data;
              ptr     <= ptr + 1'b1;
              sda_low <= ~rd_data[7];
              bitcnt  <= 4'd1;
              st      <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
  import i2c_eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_low,
  input  logic [SEL_BITS-1:0] dev_sel,
  input  logic                pl_valid,
  output logic                pl_ready,
  input  logic [ADDR_W-1:0]   pl_addr,
  input  logic [7:0]          pl_data
);
  localparam int PAGE_BITS = (ADDR_W > 8) ? (ADDR_W - 8) : 0;

  logic scl_q, sda_q, scl_rise, scl_fall, start_c, stop_c;
  logic dev_hit, idle;
  logic [SEL_BITS-1:0] dev_page;
  logic [7:1]          dev_field;
  logic [ADDR_W-1:0]   rd_addr;
  logic [7:0]          rd_data;

  eep_bus_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_q    (scl_q),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  eep_dev_match #(.PAGE_BITS(PAGE_BITS)) u_match (
    .dev_field (dev_field),
    .dev_sel   (dev_sel),
    .hit       (dev_hit),
    .page      (dev_page)
  );

  eep_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (pl_valid & pl_ready),
    .wr_addr (pl_addr),
    .wr_data (pl_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  eep_rd_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .sda_in    (sda_q),
    .dev_hit   (dev_hit),
    .dev_page  (dev_page),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .dev_field (dev_field),
    .sda_low   (sda_pull_low),
    .idle      (idle)
  );

  assign pl_ready = idle;
endmodule

// File: rtl/i2c_eeprom_rd_chk.sv
module i2c_eeprom_rd_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic scl_rise,
  input logic scl_fall,
  input logic start_c,
  input logic stop_c,
  input logic sda_pull_low,
  input logic pl_ready
);
  // R1: bus events are mutually exclusive
  p_evt_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_c, stop_c, scl_rise, scl_fall}));

  // R1: the line is free after a stop
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_pull_low);

  // R8: drive moves only after a falling edge, start or stop
  p_drive_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> $past(scl_fall || start_c || stop_c));

  // R8: steady while SCL stays high with no bus condition
  p_steady_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q) && !$past(start_c || stop_c)) |-> $stable(sda_pull_low));

  // R2: an ACK begins only on a falling edge
  p_ack_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> $past(scl_fall));

  // R9: driving the line means a frame is active, so preload is held off
  p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> !pl_ready);
endmodule

bind i2c_eeprom_rd i2c_eeprom_rd_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_q        (scl_q),
  .scl_rise     (scl_rise),
  .scl_fall     (scl_fall),
  .start_c      (start_c),
  .stop_c       (stop_c),
  .sda_pull_low (sda_pull_low),
  .pl_ready     (pl_ready)
);

// File: tb/tb_i2c_eeprom_rd.sv
module tb_i2c_eeprom_rd;
  localparam int AW = 7;
  localparam int H  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_low;
  logic pl_valid = 1'b0;
  logic pl_ready;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic [2:0] dev_sel = 3'b101;
  logic sda_bus;

  logic [7:0] model [128];
  logic [6:0] exp_ptr = '0;
  int n_chk = 0;
  int n_fail = 0;
  int edge_viol = 0;
  bit done = 1'b0;
  logic prev_drv = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull_low;

  i2c_eeprom_rd #(.ADDR_W(AW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_pull_low (sda_pull_low),
    .dev_sel      (dev_sel),
    .pl_valid     (pl_valid),
    .pl_ready     (pl_ready),
    .pl_addr      (pl_addr),
    .pl_data      (pl_data)
  );

  // R8 monitor: drive must not move while master holds SCL high
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_pull_low !== prev_drv && scl_m) edge_viol++;
      prev_drv = sda_pull_low;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; wt(H);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0;
  endtask

  task automatic rd_bit(output logic b);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H/2);
    b = sda_bus; wt(H/2);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      v[i] = b;
    end
    wr_bit(~mack);
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_valid = 1'b1; pl_addr = a; pl_data = d;
    while (!pl_ready) @(negedge clk);
    @(negedge clk);
    pl_valid = 1'b0;
    model[a] = d;
  endtask

  // reads n bytes from the pointer, checking each against the model
  task automatic read_stream(input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n-1, v);
      chk(req, v, model[exp_ptr]);
      exp_ptr = exp_ptr + 7'd1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wt(5);
    chk("R8 reset drive", {7'd0, sda_pull_low}, 8'h00);
    chk("R9 reset ready", {7'd0, pl_ready}, 8'h01);
    rst_n = 1'b1; wt(5);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 128; i++) preload(AW'(i), 8'(((i * 37) + 11) ^ 8'h96));
    chk("R9 ready idle", {7'd0, pl_ready}, 8'h01);
  endtask

  task automatic t_mismatch();
    logic ack;
    logic [7:0] v;
    bus_start();
    send_byte(8'b1010_011_0, ack);
    chk("R2 wrong select nack", {7'd0, ack}, 8'h00);
    bus_stop();
    bus_start();
    send_byte(8'b1011_101_1, ack);
    chk("R2 wrong type nack", {7'd0, ack}, 8'h00);
    recv_byte(1'b1, v);
    chk("R2 ignored until start", v, 8'hFF);
    bus_stop();
  endtask

  task automatic t_random(input logic [7:0] wa, input int n, input string req);
    logic ack;
    bus_start();
    send_byte(8'b1010_101_0, ack);
    chk("R2 write select ack", {7'd0, ack}, 8'h01);
    send_byte(wa, ack);
    chk("R3 word address ack", {7'd0, ack}, 8'h01);
    exp_ptr = wa[6:0];
    bus_start();
    send_byte(8'b1010_101_1, ack);
    chk("R2 read select ack", {7'd0, ack}, 8'h01);
    read_stream(n, req);
  endtask

  task automatic t_current(input string req);
    logic ack;
    bus_start();
    send_byte(8'b1010_101_1, ack);
    chk("R5 current ack", {7'd0, ack}, 8'h01);
    read_stream(1, req);
    bus_stop();
  endtask

  task automatic t_seq_wrap();
    logic [7:0] v;
    t_random(8'h7E, 4, "R6 sequential wrap");
    recv_byte(1'b0, v);
    chk("R7 released after nack", v, 8'hFF);
    bus_stop();
    t_current("R5 after sequential");
  endtask

  task automatic t_abort();
    logic ack;
    bus_start();
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1); wr_bit(1'b0);
    bus_stop();
    t_current("R1 stop mid-byte keeps pointer");
    bus_start();
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
    bus_start();
    send_byte(8'b1010_101_1, ack);
    chk("R1 repeated start mid-byte ack", {7'd0, ack}, 8'h01);
    read_stream(1, "R1 read after restart");
    bus_stop();
  endtask

  task automatic t_wr_data();
    logic ack;
    bus_start();
    send_byte(8'b1010_101_0, ack);
    send_byte(8'h40, ack);
    chk("R3 address ack", {7'd0, ack}, 8'h01);
    send_byte(8'h77, ack);
    chk("R3 data byte nack", {7'd0, ack}, 8'h00);
    bus_stop();
    exp_ptr = 7'h40;
    t_current("R3 pointer loaded, memory unchanged");
  endtask

  task automatic t_gate();
    logic ack;
    bus_start();
    send_byte(8'b1010_101_0, ack);
    chk("R9 ready low in frame", {7'd0, pl_ready}, 8'h00);
    pl_valid = 1'b1; pl_addr = 7'h41; pl_data = 8'h00;
    wt(30);
    pl_valid = 1'b0;
    send_byte(8'h41, ack);
    exp_ptr = 7'h41;
    bus_start();
    send_byte(8'b1010_101_1, ack);
    read_stream(1, "R9 blocked preload no effect");
    bus_stop();
    preload(7'h50, 8'hC3);
    t_random(8'h50, 1, "R9 preload handshake");
    bus_stop();
  endtask

  initial begin
    t_reset();
    t_fill();
    t_mismatch();
    t_random(8'h15, 1, "R4 random read");
    bus_stop();
    t_current("R5 current after random");
    t_random(8'h85, 1, "R3 WA7 ignored");
    bus_stop();
    t_seq_wrap();
    t_abort();
    t_wr_data();
    t_gate();
    chk("R8 drive only while SCL low", 8'(edge_viol), 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule